// File: doc/BRIEF.md
# LIN Break and Sync Timer

This block watches the receive line of a LIN bus, after a two-flop synchroniser, and recognises the header that opens every frame. A falling edge on an idle bus starts a break timer. The timer advances once per pulse of a slow sample tick of roughly 131 kHz. When the count passes a programmable limit, the low period counts as a valid break and a sticky break flag is raised. A limit of 63 ticks is about 480 µs, a little over nine and a half bit times.

After the break, falling edges are numbered along the frame. The falling edge that opened the break is edge 1, and the five falling edges of the 0x55 sync byte are edges 2 to 6. Two programmable edge numbers mark where the measurement starts and where it stops. When the stop edge arrives, the number of system-clock cycles since the start edge is latched for baud-rate derivation. A sticky stop flag is raised if its enable is set. Optionally, the line is hidden from the UART from break qualification until the bus is high again after the stop edge, so that the UART sees neither the break nor the sync byte.

The controller is one state machine. Its states are S_CLEAR (soft-reset cycle), S_IDLE, S_BREAK (timing a low period), S_QUAL (break qualified, waiting for the line to rise), S_SYNC (numbering falling edges) and S_TAIL (stop edge seen, waiting for the line to go high). Its transitions are:

- S_IDLE to S_BREAK on a falling edge.
- S_BREAK to S_QUAL when the timer passes the limit.
- S_BREAK to S_IDLE on an early rising edge (abort).
- S_QUAL to S_SYNC on the rising edge.
- S_SYNC to S_TAIL on the stop edge.
- S_SYNC to S_QUAL when a low period inside the sync passes the limit (restart).
- S_TAIL to S_IDLE when the line is high.
- Any state to S_CLEAR on soft reset.
- Any state to S_IDLE when disabled.
- S_CLEAR to S_IDLE after one cycle.

Top module: `lin_sync_timer`

## Requirements
- R1: The line passes through two synchronising flops. While ungated, `uart_rx` follows `line_in` two clock cycles later.
- R2: While enabled and idle, a falling edge starts the break timer, which advances on each `slow_tick`. Once the count exceeds `break_limit` (after `break_limit`+1 ticks), `brk_flag` is set.
- R3: A rising edge before the limit is exceeded aborts the measurement. It sets no flag and returns to idle, and a sync byte that follows such an abort raises no stop flag.
- R4: The rising edge that ends a qualified break starts edge numbering. The break's own falling edge is number 1, and each later falling edge adds one.
- R5: On the falling edge whose number equals `stop_edge`, `sync_cycles` is captured. `stop_flag` is set only if `stop_irq_en` is 1.
- R6: `sync_cycles` holds the clock cycles between falling edge `start_edge` and falling edge `stop_edge`, for 2 <= `start_edge` < `stop_edge`. For a 0x55 sync byte of bit time T this is (`stop_edge` - `start_edge`) * 2T.
- R7: With `gate_en` = 1, `uart_rx` is held at 1 from break qualification until the line is high after the stop edge. After that it follows the line again.
- R8: Both flags are sticky. Writing 1 to `irq_clr[0]` clears `brk_flag` and writing 1 to `irq_clr[1]` clears `stop_flag`; each bit clears only its own flag. A set in the same cycle wins.
- R9: A low period during edge numbering that exceeds `break_limit` ticks counts as a new break. It sets `brk_flag` and restarts the numbering.
- R10: A `soft_rst` pulse clears both flags and `sync_cycles` and returns the controller to idle. `reset_done` is 0 for exactly the following cycle and 1 otherwise.
- R11: With `enable` = 0, falling edges are ignored. No flag is set, `sync_cycles` is unchanged and `uart_rx` is not gated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_in | input | 1 | Asynchronous LIN receive line |
| slow_tick | input | 1 | One-cycle pulse at the slow sample rate |
| enable | input | 1 | Enables break and sync detection |
| gate_en | input | 1 | Hides the line from the UART during the header |
| stop_irq_en | input | 1 | Enables the stop flag |
| soft_rst | input | 1 | Pulse that clears the interface |
| break_limit | input | BRK_W | Tick count that a break must exceed |
| start_edge | input | EDGE_W | Edge number that starts the measurement |
| stop_edge | input | EDGE_W | Edge number that ends synchronisation |
| irq_clr | input | 2 | Write-one-to-clear: bit 0 break, bit 1 stop |
| uart_rx | output | 1 | Receive line as seen by the UART |
| brk_flag | output | 1 | Sticky break-compare flag |
| stop_flag | output | 1 | Sticky stop-condition flag |
| sync_cycles | output | SPAN_W | Captured start-to-stop duration in clock cycles |
| reset_done | output | 1 | Low during the soft-reset cycle |

## Verification
The bench places break lengths on both sides of the limit with a tick margin, so that a design comparing with the wrong bound or counting cycles instead of ticks would flag a short break or miss a long one. It sends a partial sync followed by a second long low; a design that does not restart the numbering would stop on the wrong edge and report the wrong duration. It samples `uart_rx` in the start bit and in the low bit after the stop edge, which catches gating that releases at the stop edge instead of when the line returns high. Random start and stop edges, bit times, enables and gating are compared with the formula (`stop_edge` - `start_edge`) * 2T, which exposes an off-by-one in the edge numbering or in the cycle count.

// File: rtl/lin_sync_pkg.sv
package lin_sync_pkg;

    typedef enum logic [2:0] {
        S_CLEAR,
        S_IDLE,
        S_BREAK,
        S_QUAL,
        S_SYNC,
        S_TAIL
    } lin_state_e;

endpackage

// File: rtl/lin_edge_detect.sv
module lin_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic line_async,
    output logic line_s,
    output logic fell,
    output logic rose
);

    logic meta_q;
    logic sync_q;
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= line_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign line_s = sync_q;
    assign fell   = prev_q & ~sync_q;
    assign rose   = ~prev_q & sync_q;

    // R1: an edge is reported for a single cycle only
    assert_fall_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fell |=> !fell);

endmodule

// File: rtl/lin_break_timer.sv
module lin_break_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    input  logic [CW-1:0] limit,
    output logic          over
);

    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (step && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign over = cnt_q > limit;

    // R2: the count saturates instead of wrapping back below the limit
    assert_brk_sat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !clr) |=> cnt_q == CNT_MAX);

    // R2: without a tick the count holds
    assert_brk_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !step) |=> $stable(cnt_q));

endmodule

// File: rtl/lin_span_counter.sv
module lin_span_counter #(
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          mark_start,
    input  logic          mark_stop,
    output logic [SW-1:0] span
);

    localparam logic [SW-1:0] SPAN_MAX = {SW{1'b1}};

    logic [SW-1:0] run_q;
    logic [SW-1:0] span_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (clr || mark_start) begin
            run_q <= '0;
        end else if (run_q != SPAN_MAX) begin
            run_q <= run_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            span_q <= '0;
        end else if (clr) begin
            span_q <= '0;
        end else if (mark_stop) begin
            span_q <= (run_q == SPAN_MAX) ? SPAN_MAX : run_q + 1'b1;
        end
    end

    assign span = span_q;

    // R6: a capture always yields a non-zero duration
    assert_span_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_stop && !clr) |=> span != '0);

    // R6: the captured value changes only on a capture or a clear
    assert_span_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mark_stop && !clr) |=> $stable(span));

endmodule

// File: rtl/lin_sync_timer.sv
module lin_sync_timer
    import lin_sync_pkg::*;
#(
    parameter int BRK_W  = 8,
    parameter int EDGE_W = 4,
    parameter int SPAN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_in,
    input  logic              slow_tick,
    input  logic              enable,
    input  logic              gate_en,
    input  logic              stop_irq_en,
    input  logic              soft_rst,
    input  logic [BRK_W-1:0]  break_limit,
    input  logic [EDGE_W-1:0] start_edge,
    input  logic [EDGE_W-1:0] stop_edge,
    input  logic [1:0]        irq_clr,
    output logic              uart_rx,
    output logic              brk_flag,
    output logic              stop_flag,
    output logic [SPAN_W-1:0] sync_cycles,
    output logic              reset_done
);

    localparam logic [EDGE_W-1:0] EDGE_ONE = EDGE_W'(1);

    lin_state_e        state_q, state_n;
    logic              line_s, fell, rose;
    logic              brk_over, brk_clr, brk_step;
    logic              brk_evt, stop_evt, start_evt;
    logic [EDGE_W-1:0] ecnt_q, ecnt_inc;
    logic              brk_flag_q, stop_flag_q;

    lin_edge_detect u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_async (line_in),
        .line_s     (line_s),
        .fell       (fell),
        .rose       (rose)
    );

    assign brk_clr  = fell | rose | !(state_q == S_BREAK || state_q == S_SYNC);
    assign brk_step = slow_tick & (state_q == S_BREAK || (state_q == S_SYNC && !line_s));

    lin_break_timer #(.CW(BRK_W)) u_brk (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (brk_clr),
        .step  (brk_step),
        .limit (break_limit),
        .over  (brk_over)
    );

    lin_span_counter #(.SW(SPAN_W)) u_span (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (soft_rst),
        .mark_start (start_evt),
        .mark_stop  (stop_evt),
        .span       (sync_cycles)
    );

    assign ecnt_inc = ecnt_q + 1'b1;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // next state and events
    always_comb begin
        state_n   = state_q;
        brk_evt   = 1'b0;
        stop_evt  = 1'b0;
        start_evt = 1'b0;
        if (soft_rst) begin
            state_n = S_CLEAR;
        end else if (!enable) begin
            state_n = S_IDLE;
        end else begin
            unique case (state_q)
                S_CLEAR: state_n = S_IDLE;
                S_IDLE: begin
                    if (fell) state_n = S_BREAK;
                end
                S_BREAK: begin
                    if (brk_over) begin
                        brk_evt = 1'b1;
                        state_n = S_QUAL;
                    end else if (rose) begin
                        state_n = S_IDLE;
                    end
                end
                S_QUAL: begin
                    if (rose) state_n = S_SYNC;
                end
                S_SYNC: begin
                    if (brk_over) begin
                        brk_evt = 1'b1;
                        state_n = S_QUAL;
                    end else if (fell) begin
                        start_evt = (ecnt_inc == start_edge);
                        if (ecnt_inc == stop_edge) begin
                            stop_evt = 1'b1;
                            state_n  = S_TAIL;
                        end
                    end
                end
                S_TAIL: begin
                    if (line_s) state_n = S_IDLE;
                end
                default: state_n = S_IDLE;
            endcase
        end
    end

    // outputs: edge number and sticky flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ecnt_q      <= '0;
            brk_flag_q  <= 1'b0;
            stop_flag_q <= 1'b0;
        end else if (soft_rst) begin
            ecnt_q      <= '0;
            brk_flag_q  <= 1'b0;
            stop_flag_q <= 1'b0;
        end else begin
            if (state_q == S_QUAL && rose) begin
                ecnt_q <= EDGE_ONE;
            end else if (state_q == S_SYNC && fell) begin
                ecnt_q <= ecnt_inc;
            end
            brk_flag_q  <= brk_evt | (brk_flag_q & ~irq_clr[0]);
            stop_flag_q <= (stop_evt & stop_irq_en) | (stop_flag_q & ~irq_clr[1]);
        end
    end

    assign brk_flag   = brk_flag_q;
    assign stop_flag  = stop_flag_q;
    assign reset_done = (state_q != S_CLEAR);
    assign uart_rx    = (gate_en && (state_q == S_QUAL || state_q == S_SYNC || state_q == S_TAIL))
                        ? 1'b1 : line_s;

    // R2 R9: the break flag rises only after the timer passed the limit
    assert_brk_needs_over_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_flag) |-> $past(brk_over));

    // R3: an early rise returns to idle with no new break flag
    assert_abort_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BREAK && rose && !brk_over && !soft_rst && enable)
        |=> (state_q == S_IDLE && !$rose(brk_flag)));

    // R5: the stop flag rises only out of edge numbering
    assert_stop_from_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_flag) |-> $past(state_q) == S_SYNC);

    // R7: the tail is left only once the line is high
    assert_tail_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_TAIL && !line_s && !soft_rst && enable) |=> state_q == S_TAIL);

    // R10: soft reset clears flags and drops reset_done for the next cycle
    assert_srst_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!brk_flag && !stop_flag && !reset_done));

    // R11: disabled means idle
    assert_off_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !soft_rst) |=> state_q == S_IDLE);

endmodule

// File: tb/lin_sync_timer_bench.sv
module lin_sync_timer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        line_in;
    logic        slow_tick;
    logic        enable;
    logic        gate_en;
    logic        stop_irq_en;
    logic        soft_rst;
    logic [7:0]  break_limit;
    logic [3:0]  start_edge;
    logic [3:0]  stop_edge;
    logic [1:0]  irq_clr;
    logic        uart_rx;
    logic        brk_flag;
    logic        stop_flag;
    logic [15:0] sync_cycles;
    logic        reset_done;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lin_sync_timer u_lin_sync_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_in     (line_in),
        .slow_tick   (slow_tick),
        .enable      (enable),
        .gate_en     (gate_en),
        .stop_irq_en (stop_irq_en),
        .soft_rst    (soft_rst),
        .break_limit (break_limit),
        .start_edge  (start_edge),
        .stop_edge   (stop_edge),
        .irq_clr     (irq_clr),
        .uart_rx     (uart_rx),
        .brk_flag    (brk_flag),
        .stop_flag   (stop_flag),
        .sync_cycles (sync_cycles),
        .reset_done  (reset_done)
    );

    function automatic int exp_span(input int t_bit, input int s_e, input int e_e);
        return (e_e - s_e) * 2 * t_bit;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_break(input int low_cyc, input int delim);
        line_in = 1'b0;
        wait_cyc(low_cyc);
        line_in = 1'b1;
        wait_cyc(delim);
    endtask

    // 0x55 with start and stop bits; optional samples of uart_rx in bits 0 and 8
    task automatic send_sync(input int t_bit, input bit chk0, input logic exp0,
                             input bit chk8, input logic exp8);
        logic [7:0] pat = 8'h55;
        for (int i = 0; i < 10; i++) begin
            if (i == 0)      line_in = 1'b0;
            else if (i == 9) line_in = 1'b1;
            else             line_in = pat[i-1];
            if ((i == 0 && chk0) || (i == 8 && chk8)) begin
                wait_cyc(t_bit / 2);
                chk((i == 0) ? "R7 uart_rx in start bit" : "R7 uart_rx after stop edge",
                    uart_rx, (i == 0) ? exp0 : exp8);
                wait_cyc(t_bit - t_bit / 2);
            end else begin
                wait_cyc(t_bit);
            end
        end
        wait_cyc(4);
    endtask

    task automatic clr_irq(input logic [1:0] m);
        irq_clr = m;
        wait_cyc(1);
        irq_clr = 2'b00;
        wait_cyc(1);
    endtask

    initial begin
        slow_tick = 1'b0;
        forever begin
            repeat (TICK_DIV - 1) @(negedge clk);
            slow_tick = 1'b1;
            @(negedge clk);
            slow_tick = 1'b0;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] last_span;
        int lim, tb, se, ee;
        bit longb, sie, gt;
        void'($urandom(32'd4711));
        rst_n = 1'b0; line_in = 1'b1; enable = 1'b0; gate_en = 1'b0;
        stop_irq_en = 1'b0; soft_rst = 1'b0; break_limit = 8'd10;
        start_edge = 4'd2; stop_edge = 4'd6; irq_clr = 2'b00;
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(2);

        // R10 reset state
        chk("R10 brk_flag after reset", brk_flag, 0);
        chk("R10 stop_flag after reset", stop_flag, 0);
        chk("R10 sync_cycles after reset", sync_cycles, 0);
        chk("R10 reset_done after reset", reset_done, 1);
        chk("R1 uart_rx idle", uart_rx, 1);

        // R1 latency, R3 tiny low aborts
        enable = 1'b1; gate_en = 1'b1; stop_irq_en = 1'b1;
        line_in = 1'b0;
        wait_cyc(1);
        chk("R1 uart_rx one cycle after fall", uart_rx, 1);
        wait_cyc(1);
        chk("R1 uart_rx two cycles after fall", uart_rx, 0);
        wait_cyc(3);
        line_in = 1'b1;
        wait_cyc(10);
        chk("R3 no flag on tiny low", brk_flag, 0);

        // R3 short break just under the limit, then a sync byte
        send_break((10 - 1) * TICK_DIV, 30);
        chk("R3 no flag on short break", brk_flag, 0);
        send_sync(40, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R3 no stop after aborted break", stop_flag, 0);
        chk("R3 span untouched", sync_cycles, 0);

        // R2 R4 R5 R6 R7 directed frame
        send_break((10 + 3) * TICK_DIV, 30);
        chk("R2 brk_flag after long break", brk_flag, 1);
        send_sync(40, 1'b1, 1'b1, 1'b1, 1'b1);
        chk("R5 stop_flag", stop_flag, 1);
        chk("R4 R6 sync_cycles edges 2 to 6", sync_cycles, exp_span(40, 2, 6));
        line_in = 1'b0;
        wait_cyc(3);
        chk("R7 ungated after bus high", uart_rx, 0);
        line_in = 1'b1;
        wait_cyc(10);

        // R8 separate clears
        clr_irq(2'b01);
        chk("R8 brk cleared by bit 0", brk_flag, 0);
        chk("R8 stop kept by bit 0", stop_flag, 1);
        clr_irq(2'b10);
        chk("R8 stop cleared by bit 1", stop_flag, 0);

        // R9 restart during edge numbering
        send_break((10 + 3) * TICK_DIV, 30);
        clr_irq(2'b11);
        line_in = 1'b0; wait_cyc(30);
        line_in = 1'b1; wait_cyc(30);
        send_break((10 + 3) * TICK_DIV, 30);
        chk("R9 brk_flag on restart", brk_flag, 1);
        send_sync(30, 1'b1, 1'b1, 1'b1, 1'b1);
        chk("R9 stop after restart", stop_flag, 1);
        chk("R9 span after restart", sync_cycles, exp_span(30, 2, 6));
        clr_irq(2'b11);
        last_span = sync_cycles;

        // R5 R6 R7 R2 R3 random frames
        for (int it = 0; it < 10; it++) begin
            lim   = $urandom_range(14, 8);
            tb    = $urandom_range(60, 20);
            se    = $urandom_range(5, 2);
            ee    = $urandom_range(6, se + 1);
            longb = 1'($urandom_range(1, 0));
            sie   = 1'($urandom_range(1, 0));
            gt    = 1'($urandom_range(1, 0));
            break_limit = 8'(lim); start_edge = 4'(se); stop_edge = 4'(ee);
            stop_irq_en = sie; gate_en = gt;
            if (longb) send_break((lim + 3 + $urandom_range(3, 0)) * TICK_DIV, 25);
            else       send_break($urandom_range(lim - 1, 1) * TICK_DIV, 25);
            chk("R2 R3 random brk_flag", brk_flag, longb);
            send_sync(tb, 1'b1, longb & gt, (longb && ee == 6), gt);
            chk("R5 random stop_flag", stop_flag, longb & sie);
            if (longb) last_span = 16'(exp_span(tb, se, ee));
            chk("R6 random sync_cycles", sync_cycles, last_span);
            clr_irq(2'b11);
        end

        // R11 disabled
        enable = 1'b0; gate_en = 1'b1; stop_irq_en = 1'b1;
        break_limit = 8'd10; start_edge = 4'd2; stop_edge = 4'd6;
        line_in = 1'b0;
        wait_cyc(20);
        chk("R11 uart_rx not gated", uart_rx, 0);
        wait_cyc(13 * TICK_DIV);
        line_in = 1'b1;
        wait_cyc(30);
        send_sync(40, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R11 no brk_flag", brk_flag, 0);
        chk("R11 no stop_flag", stop_flag, 0);
        chk("R11 span unchanged", sync_cycles, last_span);

        // R10 soft reset after a full frame
        enable = 1'b1;
        send_break(13 * TICK_DIV, 30);
        send_sync(40, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R10 flags set before soft reset", {brk_flag, stop_flag}, 2'b11);
        soft_rst = 1'b1;
        wait_cyc(1);
        soft_rst = 1'b0;
        chk("R10 reset_done low", reset_done, 0);
        chk("R10 brk cleared", brk_flag, 0);
        chk("R10 stop cleared", stop_flag, 0);
        chk("R10 span cleared", sync_cycles, 0);
        wait_cyc(1);
        chk("R10 reset_done back high", reset_done, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule